// File: doc/BRIEF.md
# Delayed-update LMS adaptive FIR filter

This block is an N-tap adaptive FIR filter in signed fixed point. Each accepted sample pair, an input `x` and a desired value `d`, gives a filter output `y` and an error `e = d - y`. The weights adapt by a least-mean-square rule, and two separate latencies are built in. The error reaches the weight update `ERR_LAT` samples late, so the input vector that goes with it is taken from an extended delay line. The filter itself multiplies by weights that are `WGT_LAT` updates old. Setting both latencies to zero gives the textbook LMS filter. The step size is a power of two, applied as an arithmetic right shift.

All samples and weights are Q1.(W-1) two's-complement numbers. The block moves forward by exactly one sample on each clock cycle in which `in_valid` is high. With `in_valid` low, nothing inside changes. A typical use is system identification or echo cancellation. The unknown system's response is driven on `d`, and `e` shows the residual.

Top module: `dlms_core`

## Requirements
- R1: A synchronous active-low reset clears every weight, both delay lines and both outputs to zero. Outputs read 0 in the cycle after a reset edge.
- R2: A clock edge with `in_valid` low changes no state. Outputs hold their values, and later results match a stream in which that cycle never happened.
- R3: Every product of two Q1.(W-1) values is computed at full precision. Then 2^(W-2) is added, the sum is shifted arithmetically right by W-1 bits, and the result is saturated to W bits.
- R4: For accepted sample k, the output y(k) is the sum over taps i = 0..N-1 of the rounded products wf(i)·x(k-i), saturated to W bits. Inputs from before reset count as zero.
- R5: The error is e(k) = sat(d(k) - y(k)), so the desired value is delayed together with y. After the clock edge that accepts sample k, `y_out` = y(k-ERR_LAT) and `e_out` = e(k-ERR_LAT), or 0 when k < ERR_LAT.
- R6: On accepting sample k, each weight i gains inc(i) = rnd(e(k-ERR_LAT)·x(k-ERR_LAT-i)) >>> MU_SHIFT. The inputs used are those that produced that error.
- R7: A weight update that would leave the W-bit signed range saturates at +(2^(W-1)-1) or -2^(W-1) and never wraps.
- R8: An update whose error is zero leaves every weight unchanged.
- R9: The weights wf used for sample k are those left after the first k-WGT_LAT updates since reset, and zero if k < WGT_LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept `x_in`/`d_in` and advance one sample |
| x_in | input | W | Input sample, signed Q1.(W-1) |
| d_in | input | W | Desired sample, signed Q1.(W-1) |
| y_out | output | W | Filter output of the sample ERR_LAT earlier |
| e_out | output | W | Error of that same sample |

## Verification
Several properties are checked on every cycle. Outputs are cleared after reset. Weights and outputs stay frozen on idle cycles. The head of the input line picks up each accepted sample. A zero error leaves the weights untouched. The numerical behaviour can only be shown by the bench's scenarios: rounding, the alignment of the late error with its own input vector, the use of stale weights, and saturation. These scenarios compare the outputs sample by sample against an independent model. They mix random streams with idle gaps, a zero-target run, a full-scale run that drives the weights into saturation, and a second reset.

// File: rtl/dlms_pkg.sv
// dlms_pkg: shared wide type and fixed-point helpers for the adaptive filter.
// Assumes every operand width is at most 31 bits, so products fit in 64.
package dlms_pkg;

    typedef logic signed [63:0] wide_t;

    // Clamp a wide value into the signed range of a w-bit word.
    function automatic wide_t sat_to(input wide_t v, input int w);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
        lo = -(wide_t'(1) <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

    // Full product with round-half-up, then drop frac fraction bits.
    function automatic wide_t mul_rnd(input wide_t a, input wide_t b, input int frac);
        return (a * b + (wide_t'(1) <<< (frac - 1))) >>> frac;
    endfunction

endpackage

// File: rtl/dlms_tap_line.sv
// dlms_tap_line: shift register of past input samples.
// Entry 0 holds the newest accepted sample. It advances only when adv is high.
// Assumes DEPTH >= 1.
module dlms_tap_line #(
    parameter int W     = 16,
    parameter int DEPTH = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [W-1:0]         x_in,
    output logic [DEPTH*W-1:0]   taps
);

    logic [W-1:0] line [DEPTH];

    // Head stage: capture the new sample.
    always_ff @(posedge clk) begin
        if (!rst_n)   line[0] <= '0;
        else if (adv) line[0] <= x_in;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        // Later stages: pass the previous stage along.
        always_ff @(posedge clk) begin
            if (!rst_n)   line[g] <= '0;
            else if (adv) line[g] <= line[g-1];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_pack
        assign taps[g*W +: W] = line[g];
    end

endmodule

// File: rtl/dlms_fir.sv
// dlms_fir: combinational inner product of N weights and N samples.
// Each product is rounded and saturated to W bits. The sum is saturated once at the end.
// Assumes Q1.(W-1) operands packed tap 0 in the low bits.
module dlms_fir
    import dlms_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic [N*W-1:0] x_vec,
    input  logic [N*W-1:0] w_vec,
    output logic [W-1:0]   y
);

    localparam int FRAC = W - 1;

    // Accumulate the rounded per-tap products and clamp the total.
    always_comb begin
        wide_t acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + sat_to(mul_rnd($signed(w_vec[i*W +: W]),
                                       $signed(x_vec[i*W +: W]), FRAC), W);
        end
        y = W'(sat_to(acc, W));
    end

endmodule

// File: rtl/dlms_err_pipe.sv
// dlms_err_pipe: delays each (y, d) pair by LAT accepted samples.
// This keeps an error formed at the tail paired with its own sample.
// LAT = 0 passes the inputs straight through.
module dlms_err_pipe #(
    parameter int W   = 16,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] y_tail,
    output logic [W-1:0] d_tail
);

    if (LAT == 0) begin : g_pass
        assign y_tail = y_in;
        assign d_tail = d_in;
    end else begin : g_pipe
        logic [W-1:0] yq [LAT];
        logic [W-1:0] dq [LAT];

        // First stage: capture the newly computed pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                yq[0] <= '0;
                dq[0] <= '0;
            end else if (adv) begin
                yq[0] <= y_in;
                dq[0] <= d_in;
            end
        end

        for (genvar g = 1; g < LAT; g++) begin : g_stage
            // Remaining stages: move the pair one sample further.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    yq[g] <= '0;
                    dq[g] <= '0;
                end else if (adv) begin
                    yq[g] <= yq[g-1];
                    dq[g] <= dq[g-1];
                end
            end
        end

        assign y_tail = yq[LAT-1];
        assign d_tail = dq[LAT-1];
    end

endmodule

// File: rtl/dlms_weight_bank.sv
// dlms_weight_bank: holds the adaptive weights and applies the LMS increment.
// It also keeps a history of past weight sets so the filter can read stale ones.
// Assumes e and x_old belong to the same (delayed) sample.
module dlms_weight_bank
    import dlms_pkg::*;
#(
    parameter int W        = 16,
    parameter int N        = 4,
    parameter int HIST     = 1,
    parameter int MU_SHIFT = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic [W-1:0]   e,
    input  logic [N*W-1:0] x_old,
    output logic [N*W-1:0] w_cur,
    output logic [N*W-1:0] w_filt
);

    localparam int FRAC = W - 1;

    logic [N*W-1:0] w_next;

    // Next weights: rounded error*input, scaled by the step, added with saturation.
    always_comb begin
        wide_t inc;
        for (int i = 0; i < N; i++) begin
            inc = sat_to(mul_rnd($signed(e), $signed(x_old[i*W +: W]), FRAC), W) >>> MU_SHIFT;
            w_next[i*W +: W] = W'(sat_to($signed(w_cur[i*W +: W]) + inc, W));
        end
    end

    // Live weight register.
    always_ff @(posedge clk) begin
        if (!rst_n)   w_cur <= '0;
        else if (adv) w_cur <= w_next;
    end

    if (HIST == 0) begin : g_fresh
        assign w_filt = w_cur;
    end else begin : g_hist
        logic [N*W-1:0] wh [HIST];

        // History head: the set in force before this update.
        always_ff @(posedge clk) begin
            if (!rst_n)   wh[0] <= '0;
            else if (adv) wh[0] <= w_cur;
        end

        for (genvar g = 1; g < HIST; g++) begin : g_stage
            // Older history entries shift back one update.
            always_ff @(posedge clk) begin
                if (!rst_n)   wh[g] <= '0;
                else if (adv) wh[g] <= wh[g-1];
            end
        end

        assign w_filt = wh[HIST-1];
    end

endmodule

// File: rtl/dlms_core.sv
// dlms_core: N-tap delayed-update LMS adaptive filter.
// The error reaches the update ERR_LAT samples late.
// The filter uses weights WGT_LAT updates old.
// Assumes Q1.(W-1) signed data, W <= 31, N >= 2, and one sample per in_valid cycle.
module dlms_core
    import dlms_pkg::*;
#(
    parameter int W        = 16,
    parameter int N_TAPS   = 4,
    parameter int ERR_LAT  = 2,
    parameter int WGT_LAT  = 1,
    parameter int MU_SHIFT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] y_out,
    output logic [W-1:0] e_out
);

    localparam int LINE_DEPTH = N_TAPS + ERR_LAT - 1;
    localparam int ALL_DEPTH  = LINE_DEPTH + 1;

    logic [LINE_DEPTH*W-1:0] line_flat;
    logic [ALL_DEPTH*W-1:0]  all_x;
    logic [N_TAPS*W-1:0]     w_cur_flat;
    logic [N_TAPS*W-1:0]     w_filt_flat;
    logic [W-1:0]            y_now;
    logic [W-1:0]            y_tail;
    logic [W-1:0]            d_tail;
    logic [W-1:0]            e_tail;

    dlms_tap_line #(.W(W), .DEPTH(LINE_DEPTH)) i_line (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .x_in  (x_in),
        .taps  (line_flat)
    );

    // Position 0 is the incoming sample, position m is x(k-m).
    assign all_x = {line_flat, x_in};

    dlms_fir #(.W(W), .N(N_TAPS)) i_fir (
        .x_vec (all_x[0 +: N_TAPS*W]),
        .w_vec (w_filt_flat),
        .y     (y_now)
    );

    dlms_err_pipe #(.W(W), .LAT(ERR_LAT)) i_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (in_valid),
        .y_in   (y_now),
        .d_in   (d_in),
        .y_tail (y_tail),
        .d_tail (d_tail)
    );

    // Error of the delayed sample, clamped to W bits.
    always_comb e_tail = W'(sat_to($signed(d_tail) - $signed(y_tail), W));

    dlms_weight_bank #(.W(W), .N(N_TAPS), .HIST(WGT_LAT), .MU_SHIFT(MU_SHIFT)) i_wbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (in_valid),
        .e      (e_tail),
        .x_old  (all_x[ERR_LAT*W +: N_TAPS*W]),
        .w_cur  (w_cur_flat),
        .w_filt (w_filt_flat)
    );

    // Output registers: present the result whose error drove this update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out <= '0;
            e_out <= '0;
        end else if (in_valid) begin
            y_out <= y_tail;
            e_out <= e_tail;
        end
    end

endmodule

// File: rtl/dlms_core_chk.sv
// dlms_core_chk: cycle-level properties of dlms_core, attached by bind.
// It observes the ports, the live weights and the head of the input line.
module dlms_core_chk #(
    parameter int W      = 16,
    parameter int N_TAPS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [W-1:0]        x_in,
    input logic [W-1:0]        y_out,
    input logic [W-1:0]        e_out,
    input logic [N_TAPS*W-1:0] w_flat,
    input logic [W-1:0]        line_head
);

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (y_out == '0 && e_out == '0 && w_flat == '0)); // R1

    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y_out) && $stable(e_out))); // R2

    AST_IDLE_WEIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(w_flat)); // R2

    AST_LINE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (line_head == $past(x_in))); // R4

    AST_ZERO_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (e_out != '0 || $stable(w_flat))); // R8

endmodule

bind dlms_core dlms_core_chk #(.W(W), .N_TAPS(N_TAPS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x_in      (x_in),
    .y_out     (y_out),
    .e_out     (e_out),
    .w_flat    (w_cur_flat),
    .line_head (line_flat[W-1:0])
);

// File: tb/test_dlms_core.sv
module test_dlms_core;

    localparam int W    = 16;
    localparam int N    = 4;
    localparam int N1   = 2;
    localparam int N2   = 1;
    localparam int MU   = 1;
    localparam int MAXS = 1500;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] x_in = '0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] y_out;
    logic [W-1:0] e_out;

    always #5 clk = ~clk;

    dlms_core #(.W(W), .N_TAPS(N), .ERR_LAT(N1), .WGT_LAT(N2), .MU_SHIFT(MU)) i_dlms_core (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .x_in (x_in), .d_in (d_in), .y_out (y_out), .e_out (e_out)
    );

    int n_checks = 0;
    int n_errors = 0;
    int k = 0;
    longint xs [MAXS];
    longint ys [MAXS];
    longint es [MAXS];
    longint wh [MAXS+1][N];

    function automatic longint sat(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // R3: full product, add half an LSB, shift by W-1, clamp
    function automatic longint rm(input longint a, input longint b);
        return sat((a * b + 16384) >>> 15);
    endfunction

    task automatic check(input string req, input longint act, input longint exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (sample %0d)", req, what, act, exp, k);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", longint'($signed(y_out)), 0, "y after reset");
        check("R1", longint'($signed(e_out)), 0, "e after reset");
        @(negedge clk);
        rst_n = 1'b1;
        k = 0;
        for (int i = 0; i < N; i++) wh[0][i] = 0;
    endtask

    // Model one accepted sample, drive it, check outputs after the edge.
    task automatic send(input longint x, input longint d, input string req);
        longint acc, ey, ee, xo, xi, wi;
        int j;
        @(negedge clk);
        in_valid = 1'b1;
        x_in = W'(x);
        d_in = W'(d);
        xs[k] = x;
        acc = 0;
        for (int i = 0; i < N; i++) begin
            wi = (k - N2 >= 0) ? wh[k-N2][i] : 0;          // R9
            xi = (k - i >= 0) ? xs[k-i] : 0;
            acc += rm(wi, xi);                              // R4
        end
        ys[k] = sat(acc);
        es[k] = sat(d - ys[k]);                             // R5
        j = k - N1;
        ey = (j >= 0) ? ys[j] : 0;
        ee = (j >= 0) ? es[j] : 0;
        for (int i = 0; i < N; i++) begin
            xo = (j - i >= 0) ? xs[j-i] : 0;
            wh[k+1][i] = sat(wh[k][i] + (rm(ee, xo) >>> MU)); // R6 R7
        end
        @(posedge clk);
        #1;
        check(req, longint'($signed(y_out)), ey, "y_out");
        check(req, longint'($signed(e_out)), ee, "e_out");
        if (k < MAXS - 1) k++;
    endtask

    task automatic idle(input longint x, input longint d);
        logic [W-1:0] py, pe;
        @(negedge clk);
        in_valid = 1'b0;
        x_in = W'(x);
        d_in = W'(d);
        py = y_out;
        pe = e_out;
        @(posedge clk);
        #1;
        check("R2", longint'($signed(y_out)), longint'($signed(py)), "y held on idle");
        check("R2", longint'($signed(e_out)), longint'($signed(pe)), "e held on idle");
    endtask

    task automatic random_run(input int count);
        longint x, px, d;
        px = 0;
        for (int it = 0; it < count; it++) begin
            x = longint'($signed(16'($urandom))) >>> 2;
            d = (x >>> 1) - (px >>> 2);
            if ($urandom % 5 == 0) idle(longint'($signed(16'($urandom))), longint'($signed(16'($urandom))));
            else begin
                send(x, d, "R3 R4 R5 R6 R9");
                px = x;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R8: zero target from zero weights keeps every weight and output at zero
        for (int it = 0; it < 10; it++) send(longint'($signed(16'($urandom))), 0, "R8");
        random_run(600);
        // R7: full-scale drive pushes weights and output into saturation
        for (int it = 0; it < 80; it++) send(32767, 32767, "R7");
        for (int it = 0; it < 30; it++) send(-32768, 32767, "R7");
        for (int it = 0; it < 5; it++) idle(1000, -1000);
        do_reset();
        random_run(60);
        @(negedge clk);
        in_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule